// File: doc/BRIEF.md
# Jump Resolution Stage

This stage decides the outcome of one jump instruction per accepted transfer for a packet-filter virtual machine. Each transfer carries the decoded instruction fields: a class bit that selects the 64-bit or the 32-bit jump class, the 4-bit jump code, the source-select bit, the 16-bit offset, the 32-bit immediate, both register operands and the current program counter, counted in instruction slots. One cycle later the stage presents a taken flag, the next program counter and an illegal flag.

Both sides use a valid/ready handshake. A transfer happens on a rising edge where valid and ready are both high. The input is ready whenever the single result register is empty or is being emptied in the same cycle. While a result waits with `out_valid` high and `out_ready` low, the result is held unchanged and no new instruction is taken. Throughput is one jump per cycle when the consumer never stalls.

Top module: `brc_unit`

## Requirements
- R1: An input transfer (`in_valid` and `in_ready` high at a rising edge) makes `out_valid` high after that edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_taken`, `out_next_pc` and `out_illegal` keep their values into the next cycle.
- R3: Code 0x0 with `in_narrow`=0 and `in_use_reg`=0 is always taken, and next PC = PC + 1 + sign-extended 16-bit offset.
- R4: Code 0x0 with `in_narrow`=1 and `in_use_reg`=0 is always taken, and next PC = PC + 1 + the 32-bit immediate as a signed value. The offset field has no effect in this case.
- R5: Code 0x0 with `in_use_reg`=1 is illegal in both classes.
- R6: Code 0x1 is taken when the first operand equals the second.
- R7: Code 0x2 is taken when dst > second operand, unsigned. Code 0x3 is taken when dst >= second operand, unsigned.
- R8: Code 0x7 is taken when dst >= second operand, with both compared as two's-complement signed values.
- R9: The second operand is `in_src` when `in_use_reg`=1. When `in_use_reg`=0 it is the immediate, sign-extended to 64 bits.
- R10: With `in_narrow`=1, conditional codes compare only bits 31:0 of each operand. For code 0x7, bit 31 is the sign.
- R11: A jump that is not taken gives next PC = PC + 1. A taken conditional jump gives PC + 1 + sign-extended offset. Arithmetic wraps at the PC width.
- R12: Codes other than 0x0, 0x1, 0x2, 0x3 and 0x7 raise `out_illegal`. An illegal result is never taken and its next PC is PC + 1.
- R13: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Stage can accept an instruction |
| in_narrow | input | 1 | 1: 32-bit jump class, 0: 64-bit jump class |
| in_code | input | 4 | Jump code |
| in_use_reg | input | 1 | 1: second operand is register, 0: immediate |
| in_off | input | 16 | Signed offset field |
| in_imm | input | 32 | Immediate field |
| in_dst | input | XLEN (64) | Destination register value |
| in_src | input | XLEN (64) | Source register value |
| in_pc | input | PC_W (32) | Current program counter, in slots |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Jump is taken |
| out_next_pc | output | PC_W (32) | Next program counter |
| out_illegal | output | 1 | Unsupported encoding |

## Verification
Two handshake events can fall in the same cycle: the held result leaves on `out_ready`, and the next instruction is captured into the same register. The bench drives `out_ready` at random with a bias toward high and offers instructions back to back. Many cycles therefore contain both a departure and an arrival. A one-entry scoreboard is judged in strict order: it first compares the departing result against its model value, then loads the model value for the arriving instruction. A lost, doubled or stale result shows up as a mismatch.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam logic [3:0] JC_ALWAYS = 4'h0;
  localparam logic [3:0] JC_EQ     = 4'h1;
  localparam logic [3:0] JC_GTU    = 4'h2;
  localparam logic [3:0] JC_GEU    = 4'h3;
  localparam logic [3:0] JC_GES    = 4'h7;
  localparam int unsigned LANE_W   = 32;
endpackage

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            narrow,
  input  logic [3:0]      code,
  input  logic            use_reg,
  input  logic [31:0]     imm,
  input  logic [XLEN-1:0] dst,
  input  logic [XLEN-1:0] src,
  output logic            taken,
  output logic            illegal,
  output logic            imm_disp
);
  logic [XLEN-1:0] rhs;
  logic [XLEN-1:0] a_u, b_u, a_s, b_s;
  logic            eq, gtu, geu, ges;

  always_comb begin
    rhs = use_reg ? src : XLEN'($signed(imm));
    if (narrow) begin
      a_u = XLEN'(dst[LANE_W-1:0]);
      b_u = XLEN'(rhs[LANE_W-1:0]);
      a_s = XLEN'($signed(dst[LANE_W-1:0]));
      b_s = XLEN'($signed(rhs[LANE_W-1:0]));
    end else begin
      a_u = dst;
      b_u = rhs;
      a_s = dst;
      b_s = rhs;
    end
    eq  = (a_u == b_u);
    gtu = (a_u > b_u);
    geu = (a_u >= b_u);
    ges = ($signed(a_s) >= $signed(b_s));
  end

  always_comb begin
    taken    = 1'b0;
    illegal  = 1'b0;
    imm_disp = 1'b0;
    case (code)
      JC_ALWAYS: begin
        if (use_reg) illegal = 1'b1;
        else begin
          taken    = 1'b1;
          imm_disp = narrow;
        end
      end
      JC_EQ:   taken = eq;
      JC_GTU:  taken = gtu;
      JC_GEU:  taken = geu;
      JC_GES:  taken = ges;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic [15:0]     off,
  input  logic [31:0]     imm,
  input  logic            imm_disp,
  input  logic            taken,
  output logic [PC_W-1:0] next_pc
);
  generate
    if (PC_W >= 32) begin : g_wide
      logic [PC_W-1:0] disp;
      always_comb begin
        disp    = imm_disp ? PC_W'($signed(imm)) : PC_W'($signed(off));
        next_pc = pc + PC_W'(1) + (taken ? disp : '0);
      end
    end else begin : g_short
      logic [31:0] disp;
      logic [31:0] sum;
      always_comb begin
        disp    = imm_disp ? imm : 32'($signed(off));
        sum     = 32'(pc) + 32'd1 + (taken ? disp : 32'd0);
        next_pc = sum[PC_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/brc_unit.sv
module brc_unit #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_narrow,
  input  logic [3:0]      in_code,
  input  logic            in_use_reg,
  input  logic [15:0]     in_off,
  input  logic [31:0]     in_imm,
  input  logic [XLEN-1:0] in_dst,
  input  logic [XLEN-1:0] in_src,
  input  logic [PC_W-1:0] in_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_taken,
  output logic [PC_W-1:0] out_next_pc,
  output logic            out_illegal
);
  typedef struct packed {
    logic            taken;
    logic            illegal;
    logic [PC_W-1:0] next_pc;
  } res_t;

  logic c_taken, c_illegal, c_imm_disp;
  logic [PC_W-1:0] c_next;
  res_t res_q;
  logic valid_q;

  brc_cond #(.XLEN(XLEN)) cond_i (
    .narrow   (in_narrow),
    .code     (in_code),
    .use_reg  (in_use_reg),
    .imm      (in_imm),
    .dst      (in_dst),
    .src      (in_src),
    .taken    (c_taken),
    .illegal  (c_illegal),
    .imm_disp (c_imm_disp)
  );

  brc_target #(.PC_W(PC_W)) tgt_i (
    .pc       (in_pc),
    .off      (in_off),
    .imm      (in_imm),
    .imm_disp (c_imm_disp),
    .taken    (c_taken),
    .next_pc  (c_next)
  );

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) res_q <= '{taken: c_taken, illegal: c_illegal, next_pc: c_next};
    end
  end

  assign out_valid   = valid_q;
  assign out_taken   = res_q.taken;
  assign out_illegal = res_q.illegal;
  assign out_next_pc = res_q.next_pc;
endmodule

// File: rtl/brc_chk.sv
module brc_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      in_code,
  input logic            in_use_reg,
  input logic [PC_W-1:0] in_pc,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic [PC_W-1:0] out_next_pc,
  input logic            out_illegal
);
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken)
      && $stable(out_next_pc) && $stable(out_illegal)); // R2
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_code == 4'h0 && !in_use_reg |=> out_taken); // R3
  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_taken || out_next_pc == $past(in_pc) + PC_W'(1)); // R11
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_taken); // R12
endmodule

bind brc_unit brc_chk #(.PC_W(PC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_code     (in_code),
  .in_use_reg  (in_use_reg),
  .in_pc       (in_pc),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_taken   (out_taken),
  .out_next_pc (out_next_pc),
  .out_illegal (out_illegal)
);

// File: tb/brc_unit_tb.sv
module brc_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        in_valid = 1'b0, in_narrow = 1'b0, in_use_reg = 1'b0, out_ready = 1'b0;
  logic [3:0]  in_code = '0;
  logic [15:0] in_off = '0;
  logic [31:0] in_imm = '0, in_pc = '0;
  logic [63:0] in_dst = '0, in_src = '0;
  logic        in_ready, out_valid, out_taken, out_illegal;
  logic [31:0] out_next_pc;

  brc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_narrow(in_narrow), .in_code(in_code), .in_use_reg(in_use_reg),
    .in_off(in_off), .in_imm(in_imm), .in_dst(in_dst), .in_src(in_src),
    .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc), .out_illegal(out_illegal)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // staged inputs, applied at the falling edge
  logic        s_valid = 0, s_narrow = 0, s_use_reg = 0;
  logic [3:0]  s_code = '0;
  logic [15:0] s_off = '0;
  logic [31:0] s_imm = '0, s_pc = '0;
  logic [63:0] s_dst = '0, s_src = '0;
  string       s_tag = "";
  int unsigned ready_bias = 75;

  bit          pend = 0, accepted = 0, hold_prev = 0;
  logic [33:0] pend_exp;
  string       pend_tag;
  logic [33:0] saved_out;

  function automatic logic [33:0] model(logic nar, logic [3:0] code, logic ureg,
      logic [15:0] off, logic [31:0] imm, logic [63:0] a, logic [63:0] b0, logic [31:0] pc);
    logic [63:0] b;
    logic [63:0] au, bu;
    logic signed [63:0] as_, bs_;
    logic tk, il;
    logic [31:0] d;
    b  = ureg ? b0 : {{32{imm[31]}}, imm};
    au = nar ? {32'd0, a[31:0]} : a;
    bu = nar ? {32'd0, b[31:0]} : b;
    as_ = nar ? {{32{a[31]}}, a[31:0]} : a;
    bs_ = nar ? {{32{b[31]}}, b[31:0]} : b;
    tk = 0; il = 0;
    d = {{16{off[15]}}, off};
    case (code)
      4'h0: if (ureg) il = 1; else begin tk = 1; if (nar) d = imm; end
      4'h1: tk = (au == bu);
      4'h2: tk = (au > bu);
      4'h3: tk = (au >= bu);
      4'h7: tk = (as_ >= bs_);
      default: il = 1;
    endcase
    return {il, tk, tk ? pc + 32'd1 + d : pc + 32'd1};
  endfunction

  function automatic string tag_for(logic nar, logic [3:0] code, logic ureg);
    case (code)
      4'h0: return ureg ? "R5" : (nar ? "R4" : "R3");
      4'h1: return "R6";
      4'h2, 4'h3: return "R7";
      4'h7: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_cycle();
    @(negedge clk);
    in_valid = s_valid; in_narrow = s_narrow; in_code = s_code; in_use_reg = s_use_reg;
    in_off = s_off; in_imm = s_imm; in_dst = s_dst; in_src = s_src; in_pc = s_pc;
    out_ready = (($urandom % 100) < ready_bias);
    #1;
    if (hold_prev)
      check(out_valid && {out_illegal, out_taken, out_next_pc} == saved_out, "R2",
            "held result changed", {30'd0, out_illegal, out_taken, out_next_pc}, {30'd0, saved_out});
    if (out_valid && !out_ready) check(!in_ready, "R2", "in_ready during stall", 64'(in_ready), 64'd0);
    if (!out_valid) check(in_ready, "R1", "in_ready when empty", 64'(in_ready), 64'd1);
    if (out_valid && out_ready) begin
      check(pend, "R1", "unexpected result", 64'd1, 64'(pend));
      if (pend)
        check({out_illegal, out_taken, out_next_pc} == pend_exp, pend_tag, "result {ill,taken,next}",
              {30'd0, out_illegal, out_taken, out_next_pc}, {30'd0, pend_exp});
      pend = 0;
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      pend_exp = model(in_narrow, in_code, in_use_reg, in_off, in_imm, in_dst, in_src, in_pc);
      pend_tag = s_tag;
      pend = 1;
    end
    hold_prev = out_valid && !out_ready;
    saved_out = {out_illegal, out_taken, out_next_pc};
  endtask

  task automatic send(logic nar, logic [3:0] code, logic ureg, logic [15:0] off,
                      logic [31:0] imm, logic [63:0] a, logic [63:0] b, logic [31:0] pc, string tag);
    s_valid = 1; s_narrow = nar; s_code = code; s_use_reg = ureg; s_off = off;
    s_imm = imm; s_dst = a; s_src = b; s_pc = pc; s_tag = tag;
    do do_cycle(); while (!accepted);
    s_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd20230803));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!out_valid, "R13", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready, "R13", "in_ready after reset", 64'(in_ready), 64'd1);
    // directed corners
    send(0, 4'h0, 0, 16'hFFFB, 32'd0, 64'd0, 64'd0, 32'd100, "R3");
    send(0, 4'h0, 0, 16'h0007, 32'd0, 64'd0, 64'd0, 32'd100, "R3");
    send(1, 4'h0, 0, 16'h0005, -32'sd200, 64'd0, 64'd0, 32'd1000, "R4");
    send(1, 4'h0, 0, 16'h0000, 32'h7FFF_0000, 64'd0, 64'd0, 32'd1, "R4");
    send(0, 4'h0, 1, 16'h0010, 32'd0, 64'd0, 64'd0, 32'd100, "R5");
    send(1, 4'h0, 1, 16'h0010, 32'd9, 64'd0, 64'd0, 32'd100, "R5");
    send(0, 4'h1, 1, 16'h0003, 32'd0, 64'd42, 64'd42, 32'd10, "R6");
    send(0, 4'h1, 1, 16'h0003, 32'd0, 64'd42, 64'd43, 32'd10, "R11");
    send(0, 4'h2, 1, 16'h0020, 32'd0, '1, 64'd1, 32'd50, "R7");
    send(0, 4'h3, 1, 16'h0020, 32'd0, 64'd9, 64'd9, 32'd50, "R7");
    send(0, 4'h7, 1, 16'h0020, 32'd0, '1, 64'd1, 32'd50, "R8");
    send(0, 4'h7, 1, 16'h0020, 32'd0, 64'd5, -64'sd3, 32'd50, "R8");
    send(0, 4'h1, 0, 16'h0002, 32'hFFFF_FFFF, '1, 64'd0, 32'd7, "R9");
    send(0, 4'h2, 0, 16'h0002, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'd0, 32'd7, "R9");
    send(1, 4'h1, 1, 16'h0004, 32'd0, 64'h1_0000_0005, 64'h2_0000_0005, 32'd20, "R10");
    send(1, 4'h7, 1, 16'h0004, 32'd0, 64'h0000_0000_8000_0000, 64'd1, 32'd20, "R10");
    send(0, 4'h1, 1, 16'h8000, 32'd0, 64'd1, 64'd1, 32'd3, "R11");
    send(0, 4'h4, 1, 16'h0004, 32'd0, 64'd1, 64'd1, 32'd30, "R12");
    send(1, 4'hF, 0, 16'h0004, 32'd0, 64'd1, 64'd1, 32'hFFFF_FFFF, "R12");
    // constrained random
    for (int n = 0; n < 1500; n++) begin
      logic [3:0] c;
      logic nar, ureg;
      logic [63:0] a, b;
      int unsigned k;
      k = $urandom % 8;
      c = (k == 7) ? 4'($urandom) : ((k == 4) ? 4'h7 : ((k > 4) ? 4'(k - 5) : 4'(k)));
      nar = 1'($urandom);
      ureg = (c == 4'h0) ? (($urandom % 6) == 0) : 1'($urandom);
      a = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = a;
        1: b = {$urandom, a[31:0]};
        2: b = a + 64'(($urandom % 3)) - 64'd1;
        default: b = {$urandom, $urandom};
      endcase
      ready_bias = (n < 750) ? 75 : 40;
      if (($urandom % 5) == 0) do_cycle();
      send(nar, c, ureg, 16'($urandom), ureg ? $urandom : b[31:0], a, b, $urandom,
           tag_for(nar, c, ureg));
    end
    ready_bias = 100;
    repeat (4) do_cycle();
    check(!pend, "R1", "result never delivered", 64'(pend), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule